// File: doc/BRIEF.md
# Predicated Vector-Loop Integer Add Sequencer

This block takes one integer add, encoded like a scalar instruction, and expands it into a series of element adds over a flat register file of 32 words of 32 bits. The caller supplies three register numbers and a vector length. It also supplies, for each operand, a flag saying whether that operand is a vector and a redirected register number that is used when the flag is set. The predicate comes from the same register file. It can be switched off, and it can be inverted.

A single opcode therefore covers the scalar-scalar, scalar-vector and vector-vector cases. The offset of an operand advances from step to step only when that operand is flagged as a vector, so a scalar operand stays on its base register. One element step runs per clock. Each step reads two registers and may write one. Steps run in order, so a step sees the results of earlier steps. A one-cycle `done` pulse marks the end of the operation. A host port loads the register file and reads it back while the block is idle.

Top module: `vec_add_seq`

## Requirements
- R1: A `start` accepted while idle with `vl` nonzero raises `busy` on the next cycle. Each element step then takes one cycle. `busy` falls and `done` is high in the cycle that follows the last step, so the start-to-done latency is steps+1 cycles.
- R2: Element step i writes register (d+od) with the 32-bit wrapped sum of register (s1+o1) and register (s2+o2). Register numbers wrap modulo 32. Steps run in order, and a later step reads the values that earlier steps wrote.
- R3: The offsets od, o1 and o2 start at 0. After each step, an offset grows by one only if its operand's vector flag is 1. Otherwise that operand stays on its base register.
- R4: When an operand's vector flag is 1, its base register is the matching `*_redir` input instead of the `*_idx` input.
- R5: Bit i of the captured predicate mask gates the write of step i. A step whose bit is 0 writes nothing, but its offsets still advance.
- R6: With `pred_en`=1, the mask is the register selected by `pred_sel`, read in the `start` cycle and inverted when `pred_inv`=1. With `pred_en`=0, the mask is all ones.
- R7: When all three vector flags are 0 and `vl` is nonzero, exactly one step is performed, and that step is gated by mask bit 0.
- R8: `vl`=0 performs no write and never raises `busy`. `done` is high in the cycle after `start`.
- R9: A `vl` larger than 32 is treated as 32.
- R10: `done` is high for exactly one cycle per operation.
- R11: While `busy` is high, `host_we` and `start` are ignored.
- R12: `host_rdata` shows the register addressed by `host_raddr` one cycle after the address is presented.
- R13: After reset, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| vl | input | 6 | Vector length; values above 32 are clamped to 32 |
| rd_idx | input | 5 | Destination register number |
| rs1_idx | input | 5 | First source register number |
| rs2_idx | input | 5 | Second source register number |
| rd_vec | input | 1 | Destination is a vector |
| rs1_vec | input | 1 | First source is a vector |
| rs2_vec | input | 1 | Second source is a vector |
| rd_redir | input | 5 | Redirected destination base, used when rd_vec=1 |
| rs1_redir | input | 5 | Redirected first source base, used when rs1_vec=1 |
| rs2_redir | input | 5 | Redirected second source base, used when rs2_vec=1 |
| pred_en | input | 1 | Enable predication |
| pred_inv | input | 1 | Invert the predicate word |
| pred_sel | input | 5 | Register holding the predicate word |
| host_we | input | 1 | Host write enable (ignored while busy) |
| host_waddr | input | 5 | Host write address |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 5 | Host read address |
| host_rdata | output | 32 | Registered host read data |
| busy | output | 1 | Element steps in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions watch the handshake on every cycle. They check that an accepted start with nonzero length raises `busy`, that a zero length gives an immediate `done` with no `busy`, and that `busy` always falls together with `done`. They also check that `done` lasts a single cycle and that no run stays busy for more than 32 cycles. Other behaviour appears only in the final register contents, so only the bench scenarios can show it. This covers the element arithmetic, the stepping of the offsets under each mix of vector flags, redirection, masking and inversion, the dependence between overlapping operands, and the dropping of host writes and restarts made while busy.

// File: rtl/vas_pkg.sv
package vas_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/vas_regfile.sv
// Register array with one write port and NRD asynchronous read ports
// (distributed-RAM style).
module vas_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int NRD  = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [XLEN-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]    raddr,
  output logic [NRD-1:0][XLEN-1:0]  rdata
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end
endmodule

// File: rtl/vas_pred.sv
// Forms the element enable mask from a register word.
module vas_pred #(
  parameter int XLEN = 32
) (
  input  logic            en,
  input  logic            inv,
  input  logic [XLEN-1:0] word,
  output logic [XLEN-1:0] mask
);
  always_comb begin
    if (!en)      mask = '1;
    else if (inv) mask = ~word;
    else          mask = word;
  end
endmodule

// File: rtl/vas_ctrl.sv
// Element-step sequencer: step count, offsets, predicate gating.
module vas_ctrl
  import vas_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5,
  parameter int VL_W = 6,
  localparam int CW  = $clog2(XLEN + 1),
  localparam int IW  = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [VL_W-1:0] vl,
  input  logic            vd,
  input  logic            v1,
  input  logic            v2,
  input  logic [AW-1:0]   base_d,
  input  logic [AW-1:0]   base_1,
  input  logic [AW-1:0]   base_2,
  input  logic [XLEN-1:0] mask_in,
  output logic [AW-1:0]   addr_d,
  output logic [AW-1:0]   addr_1,
  output logic [AW-1:0]   addr_2,
  output logic            elem_we,
  output logic            busy,
  output logic            done
);
  seq_state_e      state_q;
  logic [CW-1:0]   idx_q, last_q, n_steps;
  logic [AW-1:0]   bd_q, b1_q, b2_q, od_q, o1_q, o2_q;
  logic            vd_q, v1_q, v2_q;
  logic [XLEN-1:0] mask_q;

  always_comb begin
    if (vl == '0)               n_steps = '0;
    else if (!(vd | v1 | v2))   n_steps = CW'(1);
    else if (vl > VL_W'(XLEN))  n_steps = CW'(XLEN);
    else                        n_steps = CW'(vl);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      done    <= 1'b0;
      idx_q   <= '0;
      last_q  <= '0;
      od_q    <= '0;
      o1_q    <= '0;
      o2_q    <= '0;
      bd_q    <= '0;
      b1_q    <= '0;
      b2_q    <= '0;
      vd_q    <= 1'b0;
      v1_q    <= 1'b0;
      v2_q    <= 1'b0;
      mask_q  <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            if (n_steps == '0) begin
              done <= 1'b1;
            end else begin
              state_q <= SEQ_RUN;
              idx_q   <= '0;
              last_q  <= n_steps - CW'(1);
              od_q    <= '0;
              o1_q    <= '0;
              o2_q    <= '0;
              bd_q    <= base_d;
              b1_q    <= base_1;
              b2_q    <= base_2;
              vd_q    <= vd;
              v1_q    <= v1;
              v2_q    <= v2;
              mask_q  <= mask_in;
            end
          end
        end
        default: begin
          idx_q <= idx_q + CW'(1);
          od_q  <= od_q + AW'(vd_q);
          o1_q  <= o1_q + AW'(v1_q);
          o2_q  <= o2_q + AW'(v2_q);
          if (idx_q == last_q) begin
            state_q <= SEQ_IDLE;
            done    <= 1'b1;
          end
        end
      endcase
    end
  end

  assign addr_d  = bd_q + od_q;
  assign addr_1  = b1_q + o1_q;
  assign addr_2  = b2_q + o2_q;
  assign busy    = (state_q == SEQ_RUN);
  assign elem_we = busy && mask_q[idx_q[IW-1:0]];
endmodule

// File: rtl/vec_add_seq.sv
module vec_add_seq #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int VL_W = 6,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [VL_W-1:0] vl,
  input  logic [AW-1:0]   rd_idx,
  input  logic [AW-1:0]   rs1_idx,
  input  logic [AW-1:0]   rs2_idx,
  input  logic            rd_vec,
  input  logic            rs1_vec,
  input  logic            rs2_vec,
  input  logic [AW-1:0]   rd_redir,
  input  logic [AW-1:0]   rs1_redir,
  input  logic [AW-1:0]   rs2_redir,
  input  logic            pred_en,
  input  logic            pred_inv,
  input  logic [AW-1:0]   pred_sel,
  input  logic            host_we,
  input  logic [AW-1:0]   host_waddr,
  input  logic [XLEN-1:0] host_wdata,
  input  logic [AW-1:0]   host_raddr,
  output logic [XLEN-1:0] host_rdata,
  output logic            busy,
  output logic            done
);
  localparam int NRD = 4;

  logic [NRD-1:0][AW-1:0]   rf_ra;
  logic [NRD-1:0][XLEN-1:0] rf_rd;
  logic [AW-1:0]   seq_ad, seq_a1, seq_a2, base_d, base_1, base_2, rf_wa;
  logic            seq_we, rf_we;
  logic [XLEN-1:0] pmask, rf_wd;

  // Redirection of vector operands
  assign base_d = rd_vec  ? rd_redir  : rd_idx;
  assign base_1 = rs1_vec ? rs1_redir : rs1_idx;
  assign base_2 = rs2_vec ? rs2_redir : rs2_idx;

  assign rf_ra[0] = seq_a1;
  assign rf_ra[1] = seq_a2;
  assign rf_ra[2] = pred_sel;
  assign rf_ra[3] = host_raddr;

  assign rf_we = busy ? seq_we : host_we;
  assign rf_wa = busy ? seq_ad : host_waddr;
  assign rf_wd = busy ? (rf_rd[0] + rf_rd[1]) : host_wdata;

  vas_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NRD)) u_rf (
    .clk(clk), .we(rf_we), .waddr(rf_wa), .wdata(rf_wd),
    .raddr(rf_ra), .rdata(rf_rd)
  );

  vas_pred #(.XLEN(XLEN)) u_pred (
    .en(pred_en), .inv(pred_inv), .word(rf_rd[2]), .mask(pmask)
  );

  vas_ctrl #(.XLEN(XLEN), .AW(AW), .VL_W(VL_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .vl(vl),
    .vd(rd_vec), .v1(rs1_vec), .v2(rs2_vec),
    .base_d(base_d), .base_1(base_1), .base_2(base_2), .mask_in(pmask),
    .addr_d(seq_ad), .addr_1(seq_a1), .addr_2(seq_a2),
    .elem_we(seq_we), .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    host_rdata <= rf_rd[3];
  end
endmodule

// File: rtl/vec_add_seq_chk.sv
module vec_add_seq_chk #(
  parameter int XLEN = 32,
  parameter int VL_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [VL_W-1:0] vl,
  input logic            busy,
  input logic            done
);
  logic [7:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 8'd1;
    else           run_len <= '0;
  end

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && vl != '0) |=> (busy && !done));

  // R1
  end_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && vl == '0) |=> (done && !busy));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !(start && vl == '0)) |=> !done);

  // R9
  run_len_chk: assert property (@(posedge clk) disable iff (rst)
    run_len <= 8'(XLEN));
endmodule

bind vec_add_seq vec_add_seq_chk #(.XLEN(XLEN), .VL_W(VL_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .vl(vl), .busy(busy), .done(done)
);

// File: tb/vec_add_seq_tb.sv
module vec_add_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [5:0] vl = '0;
  logic [4:0] rd_idx = '0, rs1_idx = '0, rs2_idx = '0;
  logic rd_vec = 1'b0, rs1_vec = 1'b0, rs2_vec = 1'b0;
  logic [4:0] rd_redir = '0, rs1_redir = '0, rs2_redir = '0;
  logic pred_en = 1'b0, pred_inv = 1'b0;
  logic [4:0] pred_sel = '0;
  logic host_we = 1'b0;
  logic [4:0] host_waddr = '0, host_raddr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic busy, done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [31:0] exp_rf [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_add_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .vl(vl),
    .rd_idx(rd_idx), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
    .rd_vec(rd_vec), .rs1_vec(rs1_vec), .rs2_vec(rs2_vec),
    .rd_redir(rd_redir), .rs1_redir(rs1_redir), .rs2_redir(rs2_redir),
    .pred_en(pred_en), .pred_inv(pred_inv), .pred_sel(pred_sel),
    .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata),
    .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, got cycle %0d expected < 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Bench model: steps computed from R2..R9
  function automatic int step_count(input logic [5:0] l, input bit a, input bit b, input bit c);
    if (l == 0) return 0;
    if (!(a | b | c)) return 1;                 // R7
    return (l > 32) ? 32 : int'(l);              // R9
  endfunction

  task automatic model(input logic [5:0] l, input logic [4:0] d, s1, s2,
                       input bit vd, v1, v2, input logic [4:0] dr, s1r, s2r,
                       input bit pe, pi, input logic [4:0] ps);
    logic [4:0] bd, b1, b2, od, o1, o2;
    logic [31:0] m;
    int n;
    bd = vd ? dr : d;                            // R4
    b1 = v1 ? s1r : s1;
    b2 = v2 ? s2r : s2;
    m  = !pe ? 32'hFFFF_FFFF : (pi ? ~exp_rf[ps] : exp_rf[ps]);  // R6
    n  = step_count(l, vd, v1, v2);
    od = '0; o1 = '0; o2 = '0;
    for (int i = 0; i < n; i++) begin
      if (m[i]) exp_rf[5'(bd + od)] = exp_rf[5'(b1 + o1)] + exp_rf[5'(b2 + o2)];  // R2, R5
      od = od + 5'(vd);                          // R3
      o1 = o1 + 5'(v1);
      o2 = o2 + 5'(v2);
    end
  endtask

  task automatic host_write(input logic [4:0] a, input logic [31:0] v);
    host_we = 1'b1; host_waddr = a; host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
    exp_rf[a] = v;
  endtask

  task automatic read_all(input string req);
    for (int r = 0; r < 32; r++) begin
      host_raddr = 5'(r);
      @(negedge clk);
      check(req, host_rdata, exp_rf[r]);         // R12 one-cycle read
    end
  endtask

  task automatic do_op(input string req, input logic [5:0] l,
                       input logic [4:0] d, s1, s2, input bit vd, v1, v2,
                       input logic [4:0] dr, s1r, s2r,
                       input bit pe, pi, input logic [4:0] ps, input bit intrude);
    int n, lat;
    n = step_count(l, vd, v1, v2);
    model(l, d, s1, s2, vd, v1, v2, dr, s1r, s2r, pe, pi, ps);
    vl = l; rd_idx = d; rs1_idx = s1; rs2_idx = s2;
    rd_vec = vd; rs1_vec = v1; rs2_vec = v2;
    rd_redir = dr; rs1_redir = s1r; rs2_redir = s2r;
    pred_en = pe; pred_inv = pi; pred_sel = ps;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    if (intrude) begin
      // R11: host write and restart while busy must be dropped
      host_we = 1'b1; host_waddr = 5'd20; host_wdata = 32'hDEAD_BEEF;
      start = 1'b1; vl = 6'd5; rd_idx = 5'd21; rd_vec = 1'b0;
    end
    while (!done && lat < 100) begin
      @(negedge clk);
      host_we = 1'b0;
      start = 1'b0;
      lat++;
    end
    host_we = 1'b0;
    start = 1'b0;
    check({req, " latency"}, 32'(lat), 32'(n + 1));
    @(negedge clk);
    check("R10 done one cycle", 32'(done), 32'd0);
    read_all({req, " regs R2/R12"});
  endtask

  initial begin
    int seed_val;
    seed_val = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R13 busy after reset", 32'(busy), 32'd0);
    check("R13 done after reset", 32'(done), 32'd0);

    for (int r = 0; r < 32; r++) host_write(5'(r), $urandom);
    host_write(5'd3, 32'h0000_00A5);             // predicate word

    // R7: all scalar, vl 7, one step only
    do_op("R7 scalar", 6'd7, 5'd10, 5'd11, 5'd12, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R8: zero length
    do_op("R8 vl zero", 6'd0, 5'd13, 5'd14, 5'd15, 1, 1, 1, 5'd1, 5'd2, 5'd4, 0, 0, 0, 0);
    // R3/R4: vector-vector with redirection, wraps past 31
    do_op("R3 R4 vec-vec wrap", 6'd8, 5'd0, 5'd0, 5'd0, 1, 1, 1, 5'd28, 5'd8, 5'd16, 0, 0, 0, 0);
    // R3: scalar source broadcast into vector dest
    do_op("R3 scalar-vector", 6'd6, 5'd9, 5'd5, 5'd0, 1, 1, 0, 5'd22, 5'd12, 5'd0, 0, 0, 0, 0);
    // R5/R6: predicate from register 3, plain and inverted
    do_op("R5 R6 pred", 6'd8, 5'd0, 5'd0, 5'd0, 1, 1, 1, 5'd24, 5'd4, 5'd12, 1, 0, 5'd3, 0);
    do_op("R5 R6 pred inv", 6'd8, 5'd0, 5'd0, 5'd0, 1, 1, 1, 5'd24, 5'd4, 5'd12, 1, 1, 5'd3, 0);
    // R2: overlapping dest/src forms a running chain
    do_op("R2 overlap chain", 6'd10, 5'd0, 5'd0, 5'd2, 1, 1, 0, 5'd5, 5'd4, 5'd2, 0, 0, 0, 0);
    // R9: vl above 32 clamps
    do_op("R9 clamp", 6'd45, 5'd0, 5'd0, 5'd7, 1, 0, 0, 5'd0, 5'd1, 5'd0, 0, 0, 0, 0);
    // R11: intrusions while busy
    do_op("R11 busy ignore", 6'd8, 5'd1, 5'd2, 5'd3, 0, 1, 0, 5'd1, 5'd4, 5'd3, 0, 0, 0, 1);

    // Random mix (R1..R6)
    for (int t = 0; t < 40; t++) begin
      do_op("R1 random", 6'($urandom_range(0, 40)),
            5'($urandom), 5'($urandom), 5'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom),
            5'($urandom), 5'($urandom), 5'($urandom),
            1'($urandom), 1'($urandom), 5'($urandom), 0);
      if (t % 8 == 0) host_write(5'($urandom), $urandom);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule